// File: doc/BRIEF.md
# 8-Bit Interval and PWM Timer

This block is an 8-bit up-counting timer with two operating modes: a periodic interval timer and a pulse-width generator. One 8-bit mode register sets it up. The counter moves forward on count-enable pulses. These pulses come either from one of five taps of a free-running prescaler on the system clock, or from rising edges of a cascade input that another timer drives. The block drives one timer output pin and a one-cycle interrupt pulse at the end of every counting period.

Software stops the timer, writes the two compare registers and the mode, and then sets the run bit. The period register sets the length of a cycle. The width register sets how long the output spends at the inverse of its idle level in PWM mode. Both compare registers may be rewritten while the timer runs. A new value is used only from the next counter clear, so no period is ever cut short. The block checks every mode write: a clock-select or mode code that is not allowed drops the whole write and sets a sticky error flag.

Top module: `tmr8_ivpwm`

## Requirements
- R1: After reset the mode register reads 00h and the counter, the output, the interrupt and the error flag are all 0. The mode register layout is: bit 7 run, bits 6:4 clock select, bits 3:2 mode, bit 1 idle output level, bit 0 output enable.
- R2: While the run bit is 0 the counter is held at 0. After a write sets the run bit, the counter increments on each count tick, and the first tick comes in the cycle after that write.
- R3: Clock-select codes 000, 001, 010, 011 and 100 give one count tick every 1, 2, 4, 64 and 1024 system clocks. A full period lasts (period register + 1) ticks.
- R4: Clock-select code 101 counts rising edges of `casc_in` after a two-flop synchronizer, one tick per edge. A level that stays high adds no further ticks.
- R5: A mode write whose clock-select field is 110 or 111, or whose mode field is 01 or 11, changes nothing in the mode register and sets `cfg_err`. `cfg_err` stays set until reset.
- R6: While the run bit is 1, a mode write updates only bits 7, 1 and 0. The clock-select and mode fields keep their values.
- R7: In interval mode (code 00) the counter clears when its value equals the period register on a tick. In that cycle `irq` pulses for one clock and the output inverts. The output starts at the idle level.
- R8: In PWM mode (code 10) the counter wraps after the period register, just as in R7. While running, the output is the inverse of the idle level whenever the counter is below the width register, and the idle level otherwise.
- R9: With the output-enable bit at 0, `tmr_out` equals the idle-level bit at all times.
- R10: A write to a compare register while the timer runs takes effect at the next counter clear. While the timer is stopped, the write takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| cmp0_wr | input | 1 | Write strobe for the period compare register |
| cmp1_wr | input | 1 | Write strobe for the width compare register |
| wdata | input | 8 | Write data shared by all three registers |
| casc_in | input | 1 | Cascade count input driven by another timer's output |
| mode_q | output | 8 | Current mode register contents |
| cfg_err | output | 1 | Sticky flag set when a mode write is rejected |
| cnt_q | output | 8 | Current counter value |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | One-cycle pulse at each counter clear |

## Verification
The bench targets several corner cases:
- A width register of 0 must keep the output idle for the whole period. A width larger than the period must keep it active for the whole period. An off-by-one compare would leave one stray cycle in either case.
- A compare rewrite in the middle of a period must stretch neither that period nor the next. A design that loads the new value at once would shorten the running period.
- A stop write issued while the timer runs must leave the clock-select and mode fields untouched.
- Prohibited codes must change nothing in the mode register. A design that decodes only part of the field would change the clock source.
- A cascade input held high must add exactly one count. A level-sensitive design would keep counting.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [2:0] {
    CK_DIV1    = 3'd0,
    CK_DIV2    = 3'd1,
    CK_DIV4    = 3'd2,
    CK_DIVMID  = 3'd3,
    CK_DIVTOP  = 3'd4,
    CK_CASCADE = 3'd5
  } clk_sel_e;

  typedef enum logic [1:0] {
    MD_INTERVAL = 2'b00,
    MD_PWM      = 2'b10
  } op_mode_e;

  typedef struct packed {
    logic       run;
    logic [2:0] cks;
    logic [1:0] md;
    logic       lvl;
    logic       oe;
  } mode_t;

  function automatic logic cks_ok(input logic [2:0] c);
    return c <= 3'(CK_CASCADE);
  endfunction

  function automatic logic md_ok(input logic [1:0] m);
    return m[0] == 1'b0;
  endfunction

  function automatic logic pwm_on(input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] width);
    return cnt < width;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] cnt);
    return cnt + 1'b1;
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int TAP_MID = 6,
  parameter int TAP_TOP = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] cks,
  input  logic       casc_in,
  output logic       tick,
  output logic       casc_pulse
);
  localparam int PRE_W = TAP_TOP;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   tap;
  logic [2:0]       sync_q;
  logic             sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  // tap[k] is high for one clock in every 2**k
  assign tap[0] = 1'b1;
  for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
    assign tap[k] = &pre_q[k-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], casc_in};
  end

  assign casc_pulse = sync_q[1] & ~sync_q[2];

  always_comb begin
    case (cks)
      CK_DIV1:    sel = tap[0];
      CK_DIV2:    sel = tap[1];
      CK_DIV4:    sel = tap[2];
      CK_DIVMID:  sel = tap[TAP_MID];
      CK_DIVTOP:  sel = tap[TAP_TOP];
      CK_CASCADE: sel = casc_pulse;
      default:    sel = 1'b0;
    endcase
  end

  assign tick = run & sel;
endmodule

// File: rtl/tmr_mode_reg.sv
module tmr_mode_reg
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output mode_t      mode_q,
  output logic       err_q
);
  logic wr_legal;

  assign wr_legal = cks_ok(wdata[6:4]) && md_ok(wdata[3:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      err_q  <= 1'b0;
    end else if (wr) begin
      if (!wr_legal) begin
        err_q <= 1'b1;
      end else begin
        mode_q.run <= wdata[7];
        mode_q.lvl <= wdata[1];
        mode_q.oe  <= wdata[0];
        if (!mode_q.run) begin
          mode_q.cks <= wdata[6:4];
          mode_q.md  <= wdata[3:2];
        end
      end
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             pwm,
  input  logic             lvl,
  input  logic             oe,
  input  logic             cmp0_wr,
  input  logic             cmp1_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q,
  output logic             tout,
  output logic             wrap
);
  logic [CNT_W-1:0] cmp0_sh, cmp1_sh, cmp0_act, cmp1_act;
  logic             tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp0_sh <= '0;
      cmp1_sh <= '0;
    end else begin
      if (cmp0_wr) cmp0_sh <= wdata;
      if (cmp1_wr) cmp1_sh <= wdata;
    end
  end

  assign wrap = run & tick & (cnt_q == cmp0_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      tgl_q    <= 1'b0;
      irq_q    <= 1'b0;
      cmp0_act <= '0;
      cmp1_act <= '0;
    end else if (!run) begin
      cnt_q    <= '0;
      tgl_q    <= 1'b0;
      irq_q    <= 1'b0;
      cmp0_act <= cmp0_sh;
      cmp1_act <= cmp1_sh;
    end else begin
      irq_q <= wrap;
      if (wrap) begin
        cnt_q    <= '0;
        tgl_q    <= ~tgl_q;
        cmp0_act <= cmp0_sh;
        cmp1_act <= cmp1_sh;
      end else if (tick) begin
        cnt_q <= cnt_next(cnt_q);
      end
    end
  end

  always_comb begin
    if (!oe || !run) tout = lvl;
    else if (pwm)    tout = lvl ^ pwm_on(cnt_q, cmp1_act);
    else             tout = lvl ^ tgl_q;
  end
endmodule

// File: rtl/tmr8_ivpwm.sv
module tmr8_ivpwm
  import tmr_pkg::*;
#(
  parameter int TAP_MID = 6,
  parameter int TAP_TOP = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic       cmp0_wr,
  input  logic       cmp1_wr,
  input  logic [7:0] wdata,
  input  logic       casc_in,
  output logic [7:0] mode_q,
  output logic       cfg_err,
  output logic [7:0] cnt_q,
  output logic       tmr_out,
  output logic       irq
);
  mode_t mode_r;
  logic  cnt_tick;
  logic  casc_pulse;
  logic  cnt_wrap;

  tmr_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (mode_wr),
    .wdata  (wdata),
    .mode_q (mode_r),
    .err_q  (cfg_err)
  );

  tmr_tick_gen #(.TAP_MID(TAP_MID), .TAP_TOP(TAP_TOP)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (mode_r.run),
    .cks        (mode_r.cks),
    .casc_in    (casc_in),
    .tick       (cnt_tick),
    .casc_pulse (casc_pulse)
  );

  tmr_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (mode_r.run),
    .tick    (cnt_tick),
    .pwm     (mode_r.md == MD_PWM),
    .lvl     (mode_r.lvl),
    .oe      (mode_r.oe),
    .cmp0_wr (cmp0_wr),
    .cmp1_wr (cmp1_wr),
    .wdata   (wdata),
    .cnt_q   (cnt_q),
    .irq_q   (irq),
    .tout    (tmr_out),
    .wrap    (cnt_wrap)
  );

  assign mode_q = mode_r;
endmodule

// File: rtl/tmr8_ivpwm_chk.sv
module tmr8_ivpwm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] mode_q,
  input logic [7:0] cnt_q,
  input logic       tmr_out,
  input logic       irq,
  input logic       cfg_err,
  input logic       casc_pulse,
  input logic       cnt_wrap
);
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[7] |=> cnt_q == 8'd0); // R2

  AST_CLK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[6:4] <= 3'd5); // R5

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[2]); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R5

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[7] |=> $stable(mode_q[6:2])); // R6

  AST_IRQ_AT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt_q == 8'd0); // R7

  AST_WRAP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap |=> irq); // R7

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[0] |-> tmr_out == mode_q[1]); // R9

  AST_CASC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    casc_pulse |=> !casc_pulse); // R4
endmodule

bind tmr8_ivpwm tmr8_ivpwm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_q     (mode_q),
  .cnt_q      (cnt_q),
  .tmr_out    (tmr_out),
  .irq        (irq),
  .cfg_err    (cfg_err),
  .casc_pulse (casc_pulse),
  .cnt_wrap   (cnt_wrap)
);

// File: tb/sim_tmr8_ivpwm.sv
`timescale 1ns/100ps
module sim_tmr8_ivpwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0, cmp0_wr = 1'b0, cmp1_wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       casc_in = 1'b0;
  logic [7:0] mode_q, cnt_q;
  logic       cfg_err, tmr_out, irq;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  tmr8_ivpwm u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .cmp0_wr(cmp0_wr),
    .cmp1_wr(cmp1_wr), .wdata(wdata), .casc_in(casc_in), .mode_q(mode_q),
    .cfg_err(cfg_err), .cnt_q(cnt_q), .tmr_out(tmr_out), .irq(irq)
  );

  // {mode, period cmp, width cmp, expected period, expected active cycles}
  localparam logic [55:0] VEC [10] = '{
    {8'h89, 8'd9, 8'd3,  16'd10,   16'd3},
    {8'h89, 8'd9, 8'd0,  16'd10,   16'd0},
    {8'h89, 8'd9, 8'd12, 16'd10,   16'd10},
    {8'h8B, 8'd4, 8'd2,  16'd5,    16'd2},
    {8'h99, 8'd3, 8'd1,  16'd8,    16'd2},
    {8'hA9, 8'd2, 8'd2,  16'd12,   16'd8},
    {8'h81, 8'd6, 8'd0,  16'd7,    16'd0},
    {8'h83, 8'd1, 8'd0,  16'd2,    16'd0},
    {8'hB1, 8'd1, 8'd0,  16'd128,  16'd0},
    {8'hC1, 8'd0, 8'd0,  16'd1024, 16'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int sel, input logic [7:0] d);
    @(negedge clk);
    wdata = d;
    mode_wr = (sel == 0);
    cmp0_wr = (sel == 1);
    cmp1_wr = (sel == 2);
    @(negedge clk);
    mode_wr = 1'b0; cmp0_wr = 1'b0; cmp1_wr = 1'b0;
  endtask

  task automatic wait_irq();
    do @(negedge clk); while (!irq);
  endtask

  task automatic span(input logic lvl, output int per, output int act);
    per = 0; act = 0;
    do begin
      @(negedge clk);
      mode_wr = 1'b0; cmp0_wr = 1'b0; cmp1_wr = 1'b0;
      per++;
      if (tmr_out != lvl) act++;
    end while (!irq);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int per, act;
    logic t0, t1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mode_q == 8'h00, "R1 mode", mode_q, 0);
    chk(cnt_q == 8'h00 && tmr_out == 1'b0 && irq == 1'b0, "R1 cnt/out/irq", {cnt_q, tmr_out, irq}, 0);
    chk(cfg_err == 1'b0, "R1 err", cfg_err, 0);

    // vector table: R3 periods, R8 PWM width, R7 interval toggle
    for (int i = 0; i < 10; i++) begin
      wr_reg(0, 8'h00);
      wr_reg(1, VEC[i][47:40]);
      wr_reg(2, VEC[i][39:32]);
      wr_reg(0, VEC[i][55:48]);
      wait_irq();
      t0 = tmr_out;
      span(VEC[i][49], per, act);
      t1 = tmr_out;
      chk(per == int'(VEC[i][31:16]), $sformatf("R3 period vec%0d", i), per, int'(VEC[i][31:16]));
      if (VEC[i][51:50] == 2'b10)
        chk(act == int'(VEC[i][15:0]), $sformatf("R8 active vec%0d", i), act, int'(VEC[i][15:0]));
      else
        chk(t0 != t1, $sformatf("R7 toggle vec%0d", i), t1, !t0);
    end
    chk(cfg_err == 1'b0, "R5 no false error", cfg_err, 0);

    // R6: running, only bits 7,1,0 change
    wr_reg(0, 8'h00);
    wr_reg(0, 8'h00);
    wr_reg(0, 8'h89);
    wr_reg(0, 8'hA3);
    chk(mode_q == 8'h8B, "R6 frozen fields", mode_q, 8'h8B);
    wr_reg(0, 8'h00);
    chk(mode_q == 8'h08, "R6 stop keeps mode", mode_q, 8'h08);
    @(negedge clk);
    chk(cnt_q == 8'h00, "R2 stop clears", cnt_q, 0);
    wr_reg(0, 8'h00);
    chk(mode_q == 8'h00, "R6 stopped accepts", mode_q, 0);

    // R2: start counting, div 1
    wr_reg(1, 8'd200);
    @(negedge clk);
    @(negedge clk);
    chk(cnt_q == 8'h00, "R2 held while stopped", cnt_q, 0);
    @(negedge clk);
    wdata = 8'h81; mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
    repeat (10) @(negedge clk);
    chk(cnt_q == 8'd10, "R2 count after start", cnt_q, 10);

    // R10: compare rewrite mid-run
    wr_reg(0, 8'h00);
    wr_reg(1, 8'd9);
    wr_reg(2, 8'd3);
    wr_reg(0, 8'h89);
    wait_irq();
    wdata = 8'd4; cmp0_wr = 1'b1;
    span(1'b0, per, act);
    chk(per == 10, "R10 old period kept", per, 10);
    span(1'b0, per, act);
    chk(per == 5, "R10 new period used", per, 5);

    // R9: output disabled
    wr_reg(0, 8'h00);
    wr_reg(1, 8'd5);
    wr_reg(2, 8'd3);
    wr_reg(0, 8'h88);
    act = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tmr_out != 1'b0) act++;
    end
    chk(act == 0, "R9 disabled low", act, 0);
    wr_reg(0, 8'h00);
    wr_reg(0, 8'h8A);
    act = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tmr_out != 1'b1) act++;
    end
    chk(act == 0, "R9 disabled high", act, 0);

    // R4: cascade edges
    wr_reg(0, 8'h00);
    wr_reg(1, 8'd200);
    wr_reg(0, 8'hD1);
    for (int k = 0; k < 5; k++) begin
      casc_in = 1'b1;
      repeat (3) @(negedge clk);
      casc_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(cnt_q == 8'd5, "R4 cascade edges", cnt_q, 5);
    casc_in = 1'b1;
    repeat (12) @(negedge clk);
    chk(cnt_q == 8'd6, "R4 held level", cnt_q, 6);
    casc_in = 1'b0;

    // R5: prohibited codes
    wr_reg(0, 8'h00);
    wr_reg(0, 8'h00);
    wr_reg(0, 8'hE9);
    chk(mode_q == 8'h00, "R5 clk code 110 ignored", mode_q, 0);
    chk(cfg_err == 1'b1, "R5 error set", cfg_err, 1);
    wr_reg(0, 8'h85);
    chk(mode_q == 8'h00, "R5 mode code 01 ignored", mode_q, 0);
    wr_reg(0, 8'hF1);
    chk(mode_q == 8'h00, "R5 clk code 111 ignored", mode_q, 0);
    wr_reg(0, 8'h01);
    chk(mode_q == 8'h01 && cfg_err == 1'b1, "R5 error sticky", {mode_q, cfg_err}, 9'h003);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule